// File: doc/BRIEF.md
# Pseudo-SRAM Power Sequencer

This block sits between a supply monitor, a power manager and the access controller of a pseudo-static RAM. It produces the timed pin sequences the memory needs around power events:

- the first initialization after the supply becomes good;
- entry into and exit from the deep power-down state;
- the strobe that programs the power-down key.

While it sequences, it owns both chip enables, the program strobe and the five key address lines. It keeps the data bus released (high-impedance request asserted). It withholds its grant from the access controller.

All waits are cycle counters. Each count is the ceiling of a nanosecond parameter divided by the clock period parameter. The long 50 µs and 350 µs holds can therefore be shortened for simulation without changing the ordering logic. Once the memory is usable, the block enters an idle state. There it raises `ready` and `grant` and passes the access controller's active-low chip enable straight to the pin. In idle it accepts power-down and key-programming requests only when that chip enable is high, meaning no access is running.

Top module: `psram_pwr_seq`

## Requirements
- R1: After reset, and whenever `supply_ok` has been low, `mem_ce2` stays low with `mem_ce1_n` high for at least ceil(T_C2L_NS/CLK_NS) cycles counted from the return of `supply_ok`.
- R2: `mem_ce2` rises only while `mem_ce1_n` is high. `mem_ce1_n` then stays high for at least ceil(T_CHH_NS/CLK_NS) cycles before `ready` rises.
- R3: `ready` and `grant` are high only in the operational idle state. Outside it, `dq_hiz` is 1 and `mem_ce1_n` is 1.
- R4: A power-down request accepted in idle keeps `mem_ce1_n` high for at least ceil(T_CS_NS/CLK_NS) cycles before `mem_ce2` falls. `mem_ce2` then stays low for at least ceil(T_PDL_NS/CLK_NS) cycles, even if wake is already requested.
- R5: `pd_req` while `acc_ce1_n` is 0 (access in progress) is ignored: `ready` stays 1 and `mem_ce2` stays 1.
- R6: After `wake_req` in power-down, `mem_ce2` rises with `mem_ce1_n` high. `mem_ce1_n` stays high for at least ceil(T_CHH_NS/CLK_NS) cycles before `ready` returns.
- R7: A program request accepted in idle drives the requested key on `mem_key` and keeps both chip enables inactive (`mem_ce1_n`=1, `mem_ce2`=1) for at least ceil(T_PES_NS/CLK_NS) cycles before `mem_pe_n` goes low. `mem_pe_n` stays low for ceil(T_PEW_NS/CLK_NS) cycles. The key stays on `mem_key` through the strobe.
- R8: A program request while `acc_ce1_n` is 0 is ignored. When power-down and program are requested in the same cycle, power-down is taken.
- R9: `supply_ok` low in any state drives `mem_ce2` low and `ready` low at the next clock edge.
- R10: In idle, `mem_ce1_n` follows `acc_ce1_n` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Memory supply at or above its minimum |
| pd_req | input | 1 | Request to enter power-down |
| wake_req | input | 1 | Request to leave power-down |
| prog_req | input | 1 | Request to program the power-down key |
| prog_key | input | KEY_W | Key value for a program request |
| acc_ce1_n | input | 1 | Access controller chip enable, active low |
| mem_ce1_n | output | 1 | Memory chip enable 1, active low |
| mem_ce2 | output | 1 | Memory chip enable 2, low selects power-down |
| mem_pe_n | output | 1 | Power-down program strobe, active low |
| mem_key | output | KEY_W | Key onto the upper address bits |
| dq_hiz | output | 1 | Data bus must be released |
| ready | output | 1 | Memory initialized and usable |
| grant | output | 1 | Access controller may run |

## Verification
The bench measures, in cycles, every hold around the chip-enable edges:

- the first CE2-low wait, and the one after a supply drop inside power-down;
- the CE1-high window after CE2 rises;
- the setup before CE2 falls;
- the program setup and strobe width.

A counter that cleared late or finished one cycle early would show a window one cycle short. A wake held from the moment of entry targets a design that cuts the power-down minimum short. Requests made while an access is active, and simultaneous requests, expose a sequencer that grabs the pins from a running access or picks the wrong sequence. The supply-loss cases catch a design that only restarts from some states.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

    typedef enum logic [3:0] {
        PS_INIT,
        PS_CE2HOLD,
        PS_IDLE,
        PS_PD_SETUP,
        PS_PD_ENTER,
        PS_PD_SLEEP,
        PS_PD_EXIT,
        PS_PG_SETUP,
        PS_PG_STROBE,
        PS_PG_HOLD
    } pwr_state_e;

    function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned period_ns);
        int unsigned c;
        c = (ns + period_ns - 1) / period_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic drives_ce2(pwr_state_e s);
        return !(s == PS_INIT || s == PS_PD_ENTER || s == PS_PD_SLEEP);
    endfunction

    function automatic logic in_prog(pwr_state_e s);
        return (s == PS_PG_SETUP || s == PS_PG_STROBE || s == PS_PG_HOLD);
    endfunction

endpackage

// File: rtl/psram_pwr_timer.sv
module psram_pwr_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [CW-1:0] lim,
    output logic          done
);
    logic [CW-1:0] cnt;

    assign done = (cnt >= lim - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/psram_pwr_fsm.sv
module psram_pwr_fsm
    import psram_pwr_pkg::*;
#(
    parameter int KEY_W     = 5,
    parameter int CW        = 16,
    parameter int C2L_CYC   = 1,
    parameter int CHH_CYC   = 1,
    parameter int CS_CYC    = 1,
    parameter int PDL_CYC   = 1,
    parameter int PES_CYC   = 1,
    parameter int PEW_CYC   = 1,
    parameter int KEYH_CYC  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             supply_ok,
    input  logic             pd_req,
    input  logic             wake_req,
    input  logic             prog_req,
    input  logic [KEY_W-1:0] prog_key,
    input  logic             acc_ce1_n,
    input  logic             tmr_done,
    output logic             tmr_clr,
    output logic [CW-1:0]    tmr_lim,
    output pwr_state_e       st,
    output logic [KEY_W-1:0] key_q
);
    pwr_state_e nxt;
    logic       key_ld;

    always_comb begin
        nxt    = st;
        key_ld = 1'b0;
        unique case (st)
            PS_INIT:      if (tmr_done) nxt = PS_CE2HOLD;
            PS_CE2HOLD:   if (tmr_done) nxt = PS_IDLE;
            PS_IDLE: begin
                if (acc_ce1_n) begin
                    if (pd_req) begin
                        nxt = PS_PD_SETUP;
                    end else if (prog_req) begin
                        nxt    = PS_PG_SETUP;
                        key_ld = 1'b1;
                    end
                end
            end
            PS_PD_SETUP:  if (tmr_done) nxt = PS_PD_ENTER;
            PS_PD_ENTER:  if (tmr_done) nxt = PS_PD_SLEEP;
            PS_PD_SLEEP:  if (wake_req) nxt = PS_PD_EXIT;
            PS_PD_EXIT:   if (tmr_done) nxt = PS_IDLE;
            PS_PG_SETUP:  if (tmr_done) nxt = PS_PG_STROBE;
            PS_PG_STROBE: if (tmr_done) nxt = PS_PG_HOLD;
            PS_PG_HOLD:   if (tmr_done) nxt = PS_IDLE;
            default:      nxt = PS_INIT;
        endcase
        if (!supply_ok) nxt = PS_INIT;
    end

    assign tmr_clr = (nxt != st) || !supply_ok;

    always_comb begin
        unique case (st)
            PS_INIT:                 tmr_lim = CW'(C2L_CYC);
            PS_CE2HOLD, PS_PD_EXIT:  tmr_lim = CW'(CHH_CYC);
            PS_PD_SETUP:             tmr_lim = CW'(CS_CYC);
            PS_PD_ENTER:             tmr_lim = CW'(PDL_CYC);
            PS_PG_SETUP:             tmr_lim = CW'(PES_CYC);
            PS_PG_STROBE:            tmr_lim = CW'(PEW_CYC);
            PS_PG_HOLD:              tmr_lim = CW'(KEYH_CYC);
            default:                 tmr_lim = CW'(1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= PS_INIT;
            key_q <= '0;
        end else begin
            st <= nxt;
            if (key_ld) key_q <= prog_key;
        end
    end

    // R8
    ignore_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (st == PS_IDLE && !acc_ce1_n && supply_ok) |=> (st == PS_IDLE));
endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
    import psram_pwr_pkg::*;
#(
    parameter int CLK_NS    = 8,
    parameter int T_C2L_NS  = 50000,
    parameter int T_CHH_NS  = 350000,
    parameter int T_CS_NS   = 10,
    parameter int T_PDL_NS  = 80,
    parameter int T_PES_NS  = 80,
    parameter int T_PEW_NS  = 80,
    parameter int T_KEYH_NS = 10,
    parameter int KEY_W     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             supply_ok,
    input  logic             pd_req,
    input  logic             wake_req,
    input  logic             prog_req,
    input  logic [KEY_W-1:0] prog_key,
    input  logic             acc_ce1_n,
    output logic             mem_ce1_n,
    output logic             mem_ce2,
    output logic             mem_pe_n,
    output logic [KEY_W-1:0] mem_key,
    output logic             dq_hiz,
    output logic             ready,
    output logic             grant
);
    localparam int C2L_CYC  = ns_to_cycles(T_C2L_NS, CLK_NS);
    localparam int CHH_CYC  = ns_to_cycles(T_CHH_NS, CLK_NS);
    localparam int CS_CYC   = ns_to_cycles(T_CS_NS, CLK_NS);
    localparam int PDL_CYC  = ns_to_cycles(T_PDL_NS, CLK_NS);
    localparam int PES_CYC  = ns_to_cycles(T_PES_NS, CLK_NS);
    localparam int PEW_CYC  = ns_to_cycles(T_PEW_NS, CLK_NS);
    localparam int KEYH_CYC = ns_to_cycles(T_KEYH_NS, CLK_NS);
    localparam int MAX_CYC  = max2(max2(C2L_CYC, CHH_CYC),
                                   max2(max2(CS_CYC, PDL_CYC), max2(max2(PES_CYC, PEW_CYC), KEYH_CYC)));
    localparam int CW       = $clog2(MAX_CYC + 1);
    localparam int HW       = $clog2(CHH_CYC + 1);

    pwr_state_e       st;
    logic [KEY_W-1:0] key_q;
    logic             tmr_clr;
    logic             tmr_done;
    logic [CW-1:0]    tmr_lim;
    logic             idle;

    psram_pwr_timer #(.CW(CW)) i_timer (
        .clk  (clk),
        .rst  (rst),
        .clr  (tmr_clr),
        .lim  (tmr_lim),
        .done (tmr_done)
    );

    psram_pwr_fsm #(
        .KEY_W(KEY_W), .CW(CW),
        .C2L_CYC(C2L_CYC), .CHH_CYC(CHH_CYC), .CS_CYC(CS_CYC), .PDL_CYC(PDL_CYC),
        .PES_CYC(PES_CYC), .PEW_CYC(PEW_CYC), .KEYH_CYC(KEYH_CYC)
    ) i_fsm (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .pd_req    (pd_req),
        .wake_req  (wake_req),
        .prog_req  (prog_req),
        .prog_key  (prog_key),
        .acc_ce1_n (acc_ce1_n),
        .tmr_done  (tmr_done),
        .tmr_clr   (tmr_clr),
        .tmr_lim   (tmr_lim),
        .st        (st),
        .key_q     (key_q)
    );

    assign idle      = (st == PS_IDLE);
    assign mem_ce1_n = idle ? acc_ce1_n : 1'b1;
    assign mem_ce2   = drives_ce2(st);
    assign mem_pe_n  = (st != PS_PG_STROBE);
    assign mem_key   = in_prog(st) ? key_q : '0;
    assign dq_hiz    = !idle;
    assign ready     = idle;
    assign grant     = idle;

    // cycles CE2 has been high, saturating; guards the long hold
    logic [HW-1:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (rst || !mem_ce2) hi_cnt <= '0;
        else if (hi_cnt != HW'(CHH_CYC)) hi_cnt <= hi_cnt + HW'(1);
    end

    // R2
    ce2_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_ce2) |-> mem_ce1_n);
    // R6
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (hi_cnt >= HW'(CHH_CYC)));
    // R4
    ce2_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(mem_ce2) && $past(supply_ok)) |-> $past(mem_ce1_n));
    // R7
    pe_window_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_pe_n |-> (mem_ce2 && mem_ce1_n));
    // R9
    supply_loss_chk: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (!mem_ce2 && !ready));
    // R3
    ready_pins_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (mem_ce2 && mem_pe_n && grant));
endmodule

// File: tb/test_psram_pwr_seq.sv
module test_psram_pwr_seq;
    localparam int KW = 5;
    localparam int N_C2L = 50;
    localparam int N_CHH = 100;
    localparam int N_CS = 2;
    localparam int N_PDL = 10;
    localparam int N_PES = 10;
    localparam int N_PEW = 10;

    logic clk = 1'b0;
    logic rst, supply_ok, pd_req, wake_req, prog_req, acc_ce1_n;
    logic [KW-1:0] prog_key;
    logic mem_ce1_n, mem_ce2, mem_pe_n, dq_hiz, ready, grant;
    logic [KW-1:0] mem_key;
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    psram_pwr_seq #(
        .CLK_NS(8), .T_C2L_NS(400), .T_CHH_NS(800), .KEY_W(KW)
    ) i_psram_pwr_seq (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .pd_req(pd_req),
        .wake_req(wake_req), .prog_req(prog_req), .prog_key(prog_key),
        .acc_ce1_n(acc_ce1_n), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
        .mem_pe_n(mem_pe_n), .mem_key(mem_key), .dq_hiz(dq_hiz),
        .ready(ready), .grant(grant)
    );

    typedef struct packed {
        logic          pd;
        logic          pg;
        logic          acc_n;
        logic [KW-1:0] key;
        logic [1:0]    outc;   // 0 none, 1 power-down, 2 program
    } vec_t;

    localparam vec_t VEC [6] = '{
        {1'b1, 1'b0, 1'b1, 5'h00, 2'd1},
        {1'b0, 1'b1, 1'b1, 5'h15, 2'd2},
        {1'b1, 1'b0, 1'b0, 5'h00, 2'd0},
        {1'b0, 1'b1, 1'b0, 5'h0A, 2'd0},
        {1'b1, 1'b1, 1'b1, 5'h1F, 2'd1},
        {1'b0, 1'b0, 1'b1, 5'h07, 2'd0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            summary();
        end
    end

    // count negedges with ce2 low until it rises
    task automatic measure_ce2_low(input string tag, input int lo, input int hi);
        int n = 0;
        bit ce1_ok = 1'b1;
        bit hiz_ok = 1'b1;
        do begin
            @(negedge clk);
            n++;
            if (!mem_ce1_n) ce1_ok = 1'b0;
            if (!dq_hiz) hiz_ok = 1'b0;
        end while (!mem_ce2 && n < 3000);
        chk(n >= lo && n <= hi, tag, n, lo);
        chk(ce1_ok && hiz_ok, {tag, " ce1 high and bus released while ce2 low"}, ce1_ok, 1);
    endtask

    // count negedges from ce2 high until ready; ce1 must stay high
    task automatic measure_to_ready(input string tag);
        int n = 0;
        bit ce1_ok = 1'b1;
        bit gr_ok = 1'b1;
        while (!ready && n < 3000) begin
            if (!mem_ce1_n) ce1_ok = 1'b0;
            if (grant) gr_ok = 1'b0;
            @(negedge clk);
            n++;
        end
        chk(n >= N_CHH && n <= N_CHH + 1, tag, n, N_CHH);
        chk(ce1_ok && gr_ok && grant, {tag, " ce1 held high, grant withheld"}, ce1_ok, 1);
    endtask

    initial begin
        rst = 1'b1; supply_ok = 1'b1; pd_req = 1'b0; wake_req = 1'b0;
        prog_req = 1'b0; acc_ce1_n = 1'b1; prog_key = '0;
        repeat (3) @(negedge clk);
        // R1 R3 reset state
        chk(!mem_ce2 && mem_ce1_n && !ready && !grant && mem_pe_n && dq_hiz && mem_key == 0,
            "R1 R3 reset outputs", {mem_ce2, ready, grant}, 0);
        rst = 1'b0;
        // R1 initial CE2 low wait
        measure_ce2_low("R1 first ce2 low cycles", N_C2L, N_C2L + 1);
        // R2 ce1 high when ce2 rises, then long hold
        chk(mem_ce1_n == 1, "R2 ce1 high at ce2 rise", mem_ce1_n, 1);
        measure_to_ready("R2 ce1 hold before ready");

        // R10 passthrough in idle
        acc_ce1_n = 1'b0; #1;
        chk(mem_ce1_n == 0, "R10 ce1 follows access low", mem_ce1_n, 0);
        acc_ce1_n = 1'b1; #1;
        chk(mem_ce1_n == 1, "R10 ce1 follows access high", mem_ce1_n, 1);

        for (int v = 0; v < 6; v++) begin
            @(negedge clk);
            pd_req = VEC[v].pd; prog_req = VEC[v].pg; acc_ce1_n = VEC[v].acc_n;
            prog_key = VEC[v].key;
            @(negedge clk);
            pd_req = 1'b0; prog_req = 1'b0; acc_ce1_n = 1'b1;
            if (VEC[v].outc == 2'd0) begin
                // R5 R8 ignored request leaves idle state intact
                chk(ready && grant && mem_ce2 && mem_pe_n, $sformatf("R5 R8 vector %0d ignored", v),
                    {ready, mem_ce2, mem_pe_n}, 7);
            end else if (VEC[v].outc == 2'd1) begin
                int s = 0;
                bit c1 = 1'b1;
                chk(!ready && !grant && dq_hiz, $sformatf("R3 vector %0d pd leaves idle", v), ready, 0);
                while (mem_ce2 && s < 100) begin
                    if (!mem_ce1_n) c1 = 1'b0;
                    s++;
                    @(negedge clk);
                end
                chk(s >= N_CS && c1, $sformatf("R4 vector %0d ce1 setup before ce2 falls", v), s, N_CS);
                wake_req = 1'b1;   // early wake: minimum low time still applies
                measure_ce2_low($sformatf("R4 vector %0d ce2 low minimum", v), N_PDL, N_PDL + 2);
                wake_req = 1'b0;
                chk(mem_ce1_n == 1, $sformatf("R6 vector %0d ce1 high at exit", v), mem_ce1_n, 1);
                measure_to_ready($sformatf("R6 vector %0d hold after wake", v));
            end else begin
                int s = 0;
                int w = 0;
                bit kok = 1'b1;
                chk(mem_key == VEC[v].key, $sformatf("R7 vector %0d key at setup", v), mem_key, VEC[v].key);
                while (mem_pe_n && s < 100) begin
                    if (!mem_ce1_n || !mem_ce2 || mem_key != VEC[v].key) kok = 1'b0;
                    s++;
                    @(negedge clk);
                end
                chk(s >= N_PES && kok, $sformatf("R7 vector %0d setup before strobe", v), s, N_PES);
                while (!mem_pe_n && w < 100) begin
                    if (mem_key != VEC[v].key) kok = 1'b0;
                    w++;
                    @(negedge clk);
                end
                chk(w == N_PEW && kok, $sformatf("R7 vector %0d strobe width and key", v), w, N_PEW);
                chk(mem_key == VEC[v].key, $sformatf("R7 vector %0d key after strobe", v), mem_key, VEC[v].key);
                w = 0;
                while (!ready && w < 100) begin
                    w++;
                    @(negedge clk);
                end
                chk(ready && mem_key == 0, $sformatf("R3 vector %0d back to idle", v), ready, 1);
            end
        end

        // R9 supply loss in idle
        @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        chk(!mem_ce2 && !ready && !grant, "R9 supply loss in idle", {mem_ce2, ready}, 0);
        supply_ok = 1'b1;
        measure_ce2_low("R1 ce2 low after supply return", N_C2L, N_C2L + 1);
        measure_to_ready("R2 hold after supply return");

        // R9 supply loss in power-down
        @(negedge clk);
        pd_req = 1'b1;
        @(negedge clk);
        pd_req = 1'b0;
        repeat (N_CS + 4) @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        chk(!mem_ce2 && !ready, "R9 supply loss in power-down", mem_ce2, 0);
        repeat (5) @(negedge clk);
        chk(!mem_ce2 && !ready, "R9 held in init while supply low", mem_ce2, 0);
        supply_ok = 1'b1;
        measure_ce2_low("R1 restart wait from power-down", N_C2L, N_C2L + 1);
        measure_to_ready("R2 hold after restart");
        summary();
    end
endmodule